// File: doc/BRIEF.md
# Reservation Station Bank with Result-Bus Wakeup

This block holds a small group of reservation stations that feed one execution unit, together with the register status table that renames destination registers onto those stations. An issue port delivers one operation per cycle with a destination register and two source registers. For each source the block records either a ready value or the number of the station that will produce it. The value comes from the block's own register file or from the result bus in that same cycle.

A single result bus carries a producer tag and a data word each cycle. Every station waiting on that tag takes the data in the same cycle. The register whose pending producer is that tag is written and stops waiting. Every cycle the lowest-numbered station that has both operands is sent to the execution unit, and that station becomes free at once.

Top module: `rs_bank`

## Requirements
- R1: After reset no station is occupied, `iss_ready` is 1, `dsp_valid` is 0, no register waits on a producer, and register i holds the value i.
- R2: An issued operation whose two sources have no pending producer is dispatched on the next cycle with `dsp_a`/`dsp_b` equal to the current register values of the first and second source.
- R3: Stations are numbered 1 to NUM_ST, and tag 0 means "value present". Issue takes the lowest-numbered free station and records that station's number as the pending producer of the destination register. `dsp_tag` carries that number.
- R4: A source whose register has a pending producer stores that producer's tag, and the station is not dispatched while either tag is nonzero.
- R5: A bus broadcast (`cdb_valid`=1) updates every station that waits on `cdb_tag` in that cycle. Each such operand takes `cdb_data`. A station left with both operands present may dispatch on the next cycle.
- R6: A broadcast whose tag equals a register's pending producer writes `cdb_data` into that register and clears its pending producer. Later issues read that value directly.
- R7: If an issue names register d as destination in the same cycle that a broadcast clears d's pending producer, the new issue's station becomes d's producer.
- R8: A source whose pending producer is being broadcast in the issue cycle takes `cdb_data` as its value and does not wait.
- R9: When several stations are ready, the lowest-numbered one is dispatched, at most one per cycle. The dispatched station is free from the next cycle.
- R10: While every station is occupied, `iss_ready` is 0. An issue request in that state occupies no station and changes no register's pending producer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue request |
| iss_op | input | OP_W | Operation code of the issued operation |
| iss_dst | input | clog2(NUM_REG) | Destination register |
| iss_src_a | input | clog2(NUM_REG) | First source register |
| iss_src_b | input | clog2(NUM_REG) | Second source register |
| iss_ready | output | 1 | A station is free; the issue is taken when iss_valid is also 1 |
| cdb_valid | input | 1 | Result bus carries a result this cycle |
| cdb_tag | input | clog2(NUM_ST+1) | Number of the station that produced the result |
| cdb_data | input | DATA_W | Result value |
| dsp_valid | output | 1 | An operation is sent to the execution unit |
| dsp_tag | output | clog2(NUM_ST+1) | Number of the dispatched station |
| dsp_op | output | OP_W | Operation code of the dispatched station |
| dsp_a | output | DATA_W | First operand value |
| dsp_b | output | DATA_W | Second operand value |

## Verification
The renaming path is tried with sources that are already present, with sources that wait on one producer, and with sources whose producer broadcasts in the issue cycle. Together these separate the register-file read, the tag capture and the issue-time forwarding. One broadcast is aimed at three waiting operands in two stations at once, to show that wakeup reaches every match and not only the first. Two stations that become ready in the same cycle show the dispatch priority. An issue that renames a register in the same cycle that register's old producer broadcasts shows which update wins. A full bank with a refused issue shows that the refused request leaves the register table and the stations untouched.

// File: rtl/rs_pkg.sv
package rs_pkg;

    localparam int DEF_NUM_ST  = 4;
    localparam int DEF_NUM_REG = 8;
    localparam int DEF_DATA_W  = 16;
    localparam int DEF_OP_W    = 4;

    // Where an operand captured at issue comes from.
    typedef enum logic [1:0] {
        SRC_REGFILE = 2'd0,
        SRC_BUS     = 2'd1,
        SRC_PENDING = 2'd2
    } src_kind_e;

endpackage

// File: rtl/rs_pick.sv
module rs_pick #(
    parameter int W = 4
) (
    input  logic [W-1:0] req,
    output logic [W-1:0] gnt,
    output logic         any
);
    always_comb begin
        logic found;
        found = 1'b0;
        gnt   = '0;
        for (int i = 0; i < W; i++) begin
            if (req[i] && !found) begin
                gnt[i] = 1'b1;
                found  = 1'b1;
            end
        end
        any = found;
    end
endmodule

// File: rtl/rs_regstat.sv
module rs_regstat #(
    parameter int NUM_REG = 8,
    parameter int DATA_W  = 16,
    parameter int TAG_W   = 3,
    localparam int REG_W  = $clog2(NUM_REG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_W-1:0]  rd_a,
    input  logic [REG_W-1:0]  rd_b,
    output logic [TAG_W-1:0]  tag_a,
    output logic [DATA_W-1:0] val_a,
    output logic [TAG_W-1:0]  tag_b,
    output logic [DATA_W-1:0] val_b,
    input  logic              ren_en,
    input  logic [REG_W-1:0]  ren_reg,
    input  logic [TAG_W-1:0]  ren_tag,
    input  logic              bus_valid,
    input  logic [TAG_W-1:0]  bus_tag,
    input  logic [DATA_W-1:0] bus_data
);
    logic [NUM_REG-1:0][TAG_W-1:0]  prod_q;
    logic [NUM_REG-1:0][DATA_W-1:0] val_q;

    for (genvar r = 0; r < NUM_REG; r++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                prod_q[r] <= '0;
                val_q[r]  <= DATA_W'(r);
            end else begin
                if (bus_valid && prod_q[r] != '0 && prod_q[r] == bus_tag) begin
                    val_q[r]  <= bus_data;
                    prod_q[r] <= '0;
                end
                // A rename in the same cycle overrides the clear above.
                if (ren_en && ren_reg == REG_W'(r)) begin
                    prod_q[r] <= ren_tag;
                end
            end
        end
    end

    assign tag_a = prod_q[rd_a];
    assign val_a = val_q[rd_a];
    assign tag_b = prod_q[rd_b];
    assign val_b = val_q[rd_b];
endmodule

// File: rtl/rs_slots.sv
module rs_slots #(
    parameter int NUM_ST = 4,
    parameter int DATA_W = 16,
    parameter int OP_W   = 4,
    parameter int TAG_W  = 3
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NUM_ST-1:0]              alloc_oh,
    input  logic [OP_W-1:0]                new_op,
    input  logic [TAG_W-1:0]               new_qj,
    input  logic [DATA_W-1:0]              new_vj,
    input  logic [TAG_W-1:0]               new_qk,
    input  logic [DATA_W-1:0]              new_vk,
    input  logic [NUM_ST-1:0]              dsp_oh,
    input  logic                           bus_valid,
    input  logic [TAG_W-1:0]               bus_tag,
    input  logic [DATA_W-1:0]              bus_data,
    output logic [NUM_ST-1:0]              busy,
    output logic [NUM_ST-1:0]              ready,
    output logic [NUM_ST-1:0][OP_W-1:0]    op_o,
    output logic [NUM_ST-1:0][DATA_W-1:0]  vj_o,
    output logic [NUM_ST-1:0][DATA_W-1:0]  vk_o
);
    typedef struct packed {
        logic              busy;
        logic [OP_W-1:0]   op;
        logic [TAG_W-1:0]  qj;
        logic [TAG_W-1:0]  qk;
        logic [DATA_W-1:0] vj;
        logic [DATA_W-1:0] vk;
    } slot_t;

    slot_t [NUM_ST-1:0] slot_q;

    for (genvar i = 0; i < NUM_ST; i++) begin : g_slot
        logic hit_j, hit_k;
        assign hit_j = bus_valid && slot_q[i].busy && slot_q[i].qj != '0 && slot_q[i].qj == bus_tag;
        assign hit_k = bus_valid && slot_q[i].busy && slot_q[i].qk != '0 && slot_q[i].qk == bus_tag;

        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[i] <= '0;
            end else if (alloc_oh[i]) begin
                slot_q[i].busy <= 1'b1;
                slot_q[i].op   <= new_op;
                slot_q[i].qj   <= new_qj;
                slot_q[i].vj   <= new_vj;
                slot_q[i].qk   <= new_qk;
                slot_q[i].vk   <= new_vk;
            end else begin
                if (dsp_oh[i]) begin
                    slot_q[i].busy <= 1'b0;
                end
                if (hit_j) begin
                    slot_q[i].vj <= bus_data;
                    slot_q[i].qj <= '0;
                end
                if (hit_k) begin
                    slot_q[i].vk <= bus_data;
                    slot_q[i].qk <= '0;
                end
            end
        end

        assign busy[i]  = slot_q[i].busy;
        assign ready[i] = slot_q[i].busy && slot_q[i].qj == '0 && slot_q[i].qk == '0;
        assign op_o[i]  = slot_q[i].op;
        assign vj_o[i]  = slot_q[i].vj;
        assign vk_o[i]  = slot_q[i].vk;
    end
endmodule

// File: rtl/rs_bank.sv
module rs_bank #(
    parameter int NUM_ST  = rs_pkg::DEF_NUM_ST,
    parameter int NUM_REG = rs_pkg::DEF_NUM_REG,
    parameter int DATA_W  = rs_pkg::DEF_DATA_W,
    parameter int OP_W    = rs_pkg::DEF_OP_W,
    localparam int TAG_W  = $clog2(NUM_ST + 1),
    localparam int REG_W  = $clog2(NUM_REG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              iss_valid,
    input  logic [OP_W-1:0]   iss_op,
    input  logic [REG_W-1:0]  iss_dst,
    input  logic [REG_W-1:0]  iss_src_a,
    input  logic [REG_W-1:0]  iss_src_b,
    output logic              iss_ready,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_data,
    output logic              dsp_valid,
    output logic [TAG_W-1:0]  dsp_tag,
    output logic [OP_W-1:0]   dsp_op,
    output logic [DATA_W-1:0] dsp_a,
    output logic [DATA_W-1:0] dsp_b
);
    import rs_pkg::*;

    logic [NUM_ST-1:0] busy_w, ready_w, free_gnt, alloc_oh_w, dsp_oh_w;
    logic              any_free, iss_fire;
    logic [TAG_W-1:0]  alloc_tag;

    logic [NUM_ST-1:0][OP_W-1:0]   st_op;
    logic [NUM_ST-1:0][DATA_W-1:0] st_vj, st_vk;

    logic [1:0][TAG_W-1:0]  rd_tag;
    logic [1:0][DATA_W-1:0] rd_val;
    logic [1:0][TAG_W-1:0]  opd_q;
    logic [1:0][DATA_W-1:0] opd_v;

    // Station allocation: lowest free slot.
    rs_pick #(.W(NUM_ST)) u_alloc_pick (
        .req (~busy_w),
        .gnt (free_gnt),
        .any (any_free)
    );

    assign iss_ready  = any_free;
    assign iss_fire   = iss_valid && any_free;
    assign alloc_oh_w = iss_fire ? free_gnt : '0;

    always_comb begin
        alloc_tag = '0;
        for (int i = 0; i < NUM_ST; i++) begin
            if (free_gnt[i]) alloc_tag = TAG_W'(i + 1);
        end
    end

    rs_regstat #(
        .NUM_REG (NUM_REG),
        .DATA_W  (DATA_W),
        .TAG_W   (TAG_W)
    ) u_regstat (
        .clk       (clk),
        .rst       (rst),
        .rd_a      (iss_src_a),
        .rd_b      (iss_src_b),
        .tag_a     (rd_tag[0]),
        .val_a     (rd_val[0]),
        .tag_b     (rd_tag[1]),
        .val_b     (rd_val[1]),
        .ren_en    (iss_fire),
        .ren_reg   (iss_dst),
        .ren_tag   (alloc_tag),
        .bus_valid (cdb_valid),
        .bus_tag   (cdb_tag),
        .bus_data  (cdb_data)
    );

    // Operand capture for both sources: register value, bus forward, or wait.
    for (genvar s = 0; s < 2; s++) begin : g_src
        src_kind_e kind;
        always_comb begin
            if (rd_tag[s] == '0) begin
                kind = SRC_REGFILE;
            end else if (cdb_valid && cdb_tag == rd_tag[s]) begin
                kind = SRC_BUS;
            end else begin
                kind = SRC_PENDING;
            end
            unique case (kind)
                SRC_REGFILE: begin opd_q[s] = '0;        opd_v[s] = rd_val[s]; end
                SRC_BUS:     begin opd_q[s] = '0;        opd_v[s] = cdb_data;  end
                default:     begin opd_q[s] = rd_tag[s]; opd_v[s] = '0;        end
            endcase
        end
    end

    rs_slots #(
        .NUM_ST (NUM_ST),
        .DATA_W (DATA_W),
        .OP_W   (OP_W),
        .TAG_W  (TAG_W)
    ) u_slots (
        .clk       (clk),
        .rst       (rst),
        .alloc_oh  (alloc_oh_w),
        .new_op    (iss_op),
        .new_qj    (opd_q[0]),
        .new_vj    (opd_v[0]),
        .new_qk    (opd_q[1]),
        .new_vk    (opd_v[1]),
        .dsp_oh    (dsp_oh_w),
        .bus_valid (cdb_valid),
        .bus_tag   (cdb_tag),
        .bus_data  (cdb_data),
        .busy      (busy_w),
        .ready     (ready_w),
        .op_o      (st_op),
        .vj_o      (st_vj),
        .vk_o      (st_vk)
    );

    // Dispatch: lowest ready slot.
    rs_pick #(.W(NUM_ST)) u_dsp_pick (
        .req (ready_w),
        .gnt (dsp_oh_w),
        .any (dsp_valid)
    );

    always_comb begin
        dsp_tag = '0;
        dsp_op  = '0;
        dsp_a   = '0;
        dsp_b   = '0;
        for (int i = 0; i < NUM_ST; i++) begin
            if (dsp_oh_w[i]) begin
                dsp_tag = TAG_W'(i + 1);
                dsp_op  = st_op[i];
                dsp_a   = st_vj[i];
                dsp_b   = st_vk[i];
            end
        end
    end
endmodule

// File: rtl/rs_bank_chk.sv
module rs_bank_chk #(
    parameter int NUM_ST = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              iss_valid,
    input logic              iss_ready,
    input logic [NUM_ST-1:0] busy,
    input logic [NUM_ST-1:0] ready,
    input logic              dsp_valid,
    input logic [NUM_ST-1:0] dsp_oh,
    input logic [NUM_ST-1:0] alloc_oh
);
    assert_single_dispatch_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dsp_oh) && (dsp_valid == (dsp_oh != '0)));

    assert_lowest_first_R9: assert property (@(posedge clk) disable iff (rst)
        dsp_valid |-> ((ready & (dsp_oh - 1'b1)) == '0));

    assert_dispatch_frees_R9: assert property (@(posedge clk) disable iff (rst)
        dsp_valid |=> ((busy & $past(dsp_oh)) == '0));

    assert_issue_occupies_R3: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_ready) |=> ($countones(busy & $past(alloc_oh)) == 1));

    assert_full_stall_R10: assert property (@(posedge clk) disable iff (rst)
        (&busy) == !iss_ready);

    assert_ready_needs_busy_R4: assert property (@(posedge clk) disable iff (rst)
        (ready & ~busy) == '0);
endmodule

bind rs_bank rs_bank_chk #(.NUM_ST(NUM_ST)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .iss_valid (iss_valid),
    .iss_ready (iss_ready),
    .busy      (busy_w),
    .ready     (ready_w),
    .dsp_valid (dsp_valid),
    .dsp_oh    (dsp_oh_w),
    .alloc_oh  (alloc_oh_w)
);

// File: tb/rs_bank_tb_top.sv
module rs_bank_tb_top;
    localparam int NST = 4;
    localparam int NRG = 8;
    localparam int DW  = 16;
    localparam int OW  = 4;
    localparam int TW  = $clog2(NST + 1);
    localparam int RW  = $clog2(NRG);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          iss_valid = 1'b0;
    logic [OW-1:0] iss_op = '0;
    logic [RW-1:0] iss_dst = '0, iss_src_a = '0, iss_src_b = '0;
    logic          iss_ready;
    logic          cdb_valid = 1'b0;
    logic [TW-1:0] cdb_tag = '0;
    logic [DW-1:0] cdb_data = '0;
    logic          dsp_valid;
    logic [TW-1:0] dsp_tag;
    logic [OW-1:0] dsp_op;
    logic [DW-1:0] dsp_a, dsp_b;

    always #2.5 clk = ~clk;

    rs_bank #(.NUM_ST(NST), .NUM_REG(NRG), .DATA_W(DW), .OP_W(OW)) dut_i (
        .clk(clk), .rst(rst),
        .iss_valid(iss_valid), .iss_op(iss_op), .iss_dst(iss_dst),
        .iss_src_a(iss_src_a), .iss_src_b(iss_src_b), .iss_ready(iss_ready),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
        .dsp_valid(dsp_valid), .dsp_tag(dsp_tag), .dsp_op(dsp_op),
        .dsp_a(dsp_a), .dsp_b(dsp_b)
    );

    typedef struct packed {
        logic [TW-1:0] tag;
        logic [OW-1:0] op;
        logic [DW-1:0] a;
        logic [DW-1:0] b;
    } dsp_item_t;

    dsp_item_t exp_q[$];
    string     req_q[$];
    int        n_checks = 0;
    int        n_fail   = 0;
    bit        done     = 1'b0;

    task automatic expect_dsp(input int tag, input int op, input int a, input int b, input string req);
        dsp_item_t it;
        it.tag = TW'(tag);
        it.op  = OW'(op);
        it.a   = DW'(a);
        it.b   = DW'(b);
        exp_q.push_back(it);
        req_q.push_back(req);
    endtask

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One cycle: drive issue and bus, then wait for the next falling edge.
    task automatic step(input bit iv, input int op, input int dst, input int sa, input int sb,
                        input bit cv, input int ct, input int cd);
        iss_valid = iv;
        iss_op    = OW'(op);
        iss_dst   = RW'(dst);
        iss_src_a = RW'(sa);
        iss_src_b = RW'(sb);
        cdb_valid = cv;
        cdb_tag   = TW'(ct);
        cdb_data  = DW'(cd);
        @(negedge clk);
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    // Monitor: every dispatch is compared against the next expected item.
    always @(negedge clk) begin
        if (!rst && dsp_valid) begin
            dsp_item_t got, want;
            string     req;
            got = {dsp_tag, dsp_op, dsp_a, dsp_b};
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R9 unexpected dispatch: actual %0h expected none", got);
            end else begin
                want = exp_q.pop_front();
                req  = req_q.pop_front();
                if (got !== want) begin
                    n_fail++;
                    $display("FAIL %s dispatch {tag,op,a,b}: actual %0h expected %0h", req, got, want);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(iss_ready == 1'b1, "R1", "iss_ready", int'(iss_ready), 1);
        check(dsp_valid == 1'b0, "R1", "dsp_valid", int'(dsp_valid), 0);

        // R2 / R1: present sources read reset register values
        expect_dsp(1, 3, 2, 3, "R2");
        step(1, 3, 1, 2, 3, 0, 0, 0);
        step(0, 0, 0, 0, 0, 1, 1, 'h100);
        check(dsp_valid == 1'b0, "R9", "dsp_valid after dispatch", int'(dsp_valid), 0);

        // R6: broadcast wrote r1
        expect_dsp(1, 5, 'h100, 'h100, "R6");
        step(1, 5, 5, 1, 1, 0, 0, 0);
        step(0, 0, 0, 0, 0, 1, 1, 'h55);

        // R3, R4, R5, R8, R9: chains and multi-waiter wakeup
        expect_dsp(1, 1, 2, 3, "R3");
        step(1, 1, 1, 2, 3, 0, 0, 0);
        step(1, 2, 4, 1, 0, 0, 0, 0);
        check(dsp_valid == 1'b0, "R4", "waiting station dispatched", int'(dsp_valid), 0);
        expect_dsp(2, 2, 'h111, 0, "R5");
        step(1, 3, 5, 4, 4, 1, 1, 'h111);
        step(1, 4, 6, 4, 5, 0, 0, 0);
        check(dsp_valid == 1'b0, "R4", "two waiting stations", int'(dsp_valid), 0);
        expect_dsp(1, 3, 'h222, 'h222, "R5");
        expect_dsp(2, 5, 'h222, 'h111, "R8");
        step(1, 5, 7, 4, 1, 1, 2, 'h222);
        check(dsp_tag == TW'(1), "R9", "lowest ready first", int'(dsp_tag), 1);
        idle();
        expect_dsp(3, 4, 'h222, 'h333, "R5");
        step(0, 0, 0, 0, 0, 1, 1, 'h333);
        step(0, 0, 0, 0, 0, 1, 2, 'h444);
        step(0, 0, 0, 0, 0, 1, 3, 'h555);
        expect_dsp(1, 6, 'h555, 'h444, "R6");
        step(1, 6, 0, 6, 7, 0, 0, 0);
        expect_dsp(2, 7, 'h333, 'h111, "R6");
        step(1, 7, 0, 5, 1, 0, 0, 0);
        step(0, 0, 0, 0, 0, 1, 1, 'h666);
        step(0, 0, 0, 0, 0, 1, 2, 'h777);

        // R7: rename in the same cycle as the old producer's broadcast
        expect_dsp(1, 9, 'h777, 'h777, "R6");
        step(1, 9, 2, 0, 0, 0, 0, 0);
        expect_dsp(2, 10, 'h888, 3, "R8");
        step(1, 10, 2, 2, 3, 1, 1, 'h888);
        step(1, 11, 0, 2, 2, 0, 0, 0);
        check(dsp_valid == 1'b0, "R7", "reader of renamed register", int'(dsp_valid), 0);
        expect_dsp(1, 11, 'h999, 'h999, "R7");
        step(0, 0, 0, 0, 0, 1, 2, 'h999);
        idle();
        step(0, 0, 0, 0, 0, 1, 1, 'hAAA);

        // R10: full bank refuses issue
        expect_dsp(1, 12, 'hAAA, 'hAAA, "R3");
        step(1, 12, 1, 0, 0, 0, 0, 0);
        step(1, 13, 1, 1, 0, 0, 0, 0);
        step(1, 14, 4, 1, 1, 0, 0, 0);
        step(1, 15, 4, 1, 0, 0, 0, 0);
        step(1, 1, 6, 4, 0, 0, 0, 0);
        check(iss_ready == 1'b0, "R10", "iss_ready when full", int'(iss_ready), 0);
        check(dsp_valid == 1'b0, "R10", "dsp_valid when full", int'(dsp_valid), 0);
        step(1, 2, 7, 0, 0, 0, 0, 0);
        check(dsp_valid == 1'b0, "R10", "refused issue dispatched", int'(dsp_valid), 0);
        check(iss_ready == 1'b0, "R10", "iss_ready still low", int'(iss_ready), 0);
        expect_dsp(2, 13, 'hB01, 'hAAA, "R5");
        step(0, 0, 0, 0, 0, 1, 1, 'hB01);
        idle();
        check(iss_ready == 1'b1, "R9", "station freed at dispatch", int'(iss_ready), 1);
        expect_dsp(1, 14, 'hB02, 'hB02, "R9");
        expect_dsp(3, 15, 'hB02, 'hAAA, "R9");
        step(0, 0, 0, 0, 0, 1, 2, 'hB02);
        idle();
        idle();
        expect_dsp(4, 1, 'hB03, 'hAAA, "R5");
        step(0, 0, 0, 0, 0, 1, 3, 'hB03);
        idle();
        step(0, 0, 0, 0, 0, 1, 4, 'hB04);
        // r7 must still hold 0x444: the refused issue did not rename it
        expect_dsp(1, 2, 'h444, 'hB04, "R10");
        step(1, 2, 0, 7, 6, 0, 0, 0);
        idle();
        idle();
        check(exp_q.size() == 0, "R9", "dispatches outstanding", exp_q.size(), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule